// File: doc/BRIEF.md
# Floating-Point Status and Exception Trap Unit

This block owns the floating-point status word of a processor's arithmetic unit. After every arithmetic operation, the datapath reports the exceptions that operation raised. The block checks them against the enable bits held in the status word. It decides whether a trap is taken, records that decision in the status word and builds a separate exception word for the trap handler. It also presents the current rounding mode as a one-hot select and a flush-to-zero enable, which the datapath reads continuously.

Software writes the status word through a load strobe. A completing operation reports through an op strobe that carries its five-bit exception vector. Both strobes are valid-only inputs: the block takes one of them every cycle and never applies back-pressure, so there is no ready signal. When both strobes arrive in the same cycle, the load is taken and the operation report is dropped. Status, exception word and trap request all change on the clock edge that takes the strobe.

Top module: `fpst_trap_unit`

## Requirements
- R1: After reset, the status word and the exception word are zero, the trap request is low, the rounding select is nearest-even (value 4'b0001) and flush-to-zero is off.
- R2: A load strobe replaces all 32 status bits with the loaded word on the next edge. It leaves the exception word unchanged and raises no trap.
- R3: When the load strobe and the op strobe are both high in one cycle, only the load takes effect: there is no trap, no change to the exception word and no masking of the loaded word.
- R4: Status bits [10:9] select the rounding mode, shown one-hot on the rounding select output: 0 gives bit 0 (nearest-even), 1 gives bit 1 (toward zero), 2 gives bit 2 (toward +infinity) and 3 gives bit 3 (toward -infinity).
- R5: Flush-to-zero equals status bit 5. The datapath applies it to both inputs and results, before rounding.
- R6: After each op, status bits [31:26] are zero and bits [25:0] keep their previous values. The only exception is the trap bit, status bit 6, which an op can set.
- R7: An op with an all-zero exception vector writes an all-zero exception word and raises no trap.
- R8: Exception vector bit k pairs with enable bit k of the status word. The bit order is [4] invalid, [3] divide-by-zero, [2] overflow, [1] underflow, [0] inexact. If the raised set ANDed with the enables is nonzero, status bit 6 is set and the trap request pulses high for exactly the cycle in which the status and exception words update.
- R9: An op that raises exceptions, none of them enabled, writes an all-zero exception word and raises no trap.
- R10: On a trap whose enabled-and-raised set contains overflow or underflow, the exception word is exactly bit 26 (condition) plus bit 29 (overflow flag), that is 32'h2400_0000.
- R11: On any other trap, the exception word holds the full raised vector in bits [31:27], in the same order as the enables, and zeros elsewhere.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ld_vld_i | input | 1 | Load strobe for the status word |
| ld_word_i | input | 32 | Status word to load |
| op_vld_i | input | 1 | Operation-complete strobe |
| op_exc_i | input | 5 | Exceptions raised by the completing operation |
| status_o | output | 32 | Current status word |
| excw_o | output | 32 | Exception word for the trap handler |
| trap_o | output | 1 | One-cycle trap request |
| rmode_o | output | 4 | One-hot rounding-mode select |
| ftz_o | output | 1 | Flush-to-zero enable |

## Verification
A corrupted status register shows at the ports in several ways. It can appear as wrong high bits after the next op, as a wrong rounding select or flush-to-zero enable on the very next cycle, or as a trap decision taken against the wrong enables. A stale exception word appears as a nonzero value after an op that raised nothing. A trap pulse that is held too long or dropped differs from the expected value one cycle after the op strobe. Each fault therefore shows up no later than the cycle after the next strobe that touches the affected state.

// File: rtl/fpst_pkg.sv
package fpst_pkg;

  // positions of the exception kinds, shared by the vector, the enables and the flags
  localparam int EX_INEXACT = 0;
  localparam int EX_UNDER   = 1;
  localparam int EX_OVER    = 2;
  localparam int EX_DIVZ    = 3;
  localparam int EX_INVAL   = 4;

  // status word fields
  localparam int ENA_LSB  = 0;
  localparam int FTZ_BIT  = 5;
  localparam int TRAP_BIT = 6;
  localparam int RND_LSB  = 9;

  // exception word fields
  localparam int COND_BIT = 26;
  localparam int FLAG_LSB = 27;

  typedef enum logic [1:0] {
    RND_NEAR = 2'd0,
    RND_ZERO = 2'd1,
    RND_PINF = 2'd2,
    RND_NINF = 2'd3
  } rnd_e;

endpackage

// File: rtl/fpst_trap_eval.sv
module fpst_trap_eval
  import fpst_pkg::*;
#(
  parameter int STAT_W = 32,
  parameter int EXC_N  = 5,
  parameter int KEEP_W = 26
) (
  input  logic [STAT_W-1:0] stat_i,
  input  logic [EXC_N-1:0]  exc_i,
  output logic [STAT_W-1:0] nxt_stat_o,
  output logic [STAT_W-1:0] nxt_excw_o,
  output logic              trap_o
);
  localparam logic [STAT_W-1:0] KEEP_MASK = {{(STAT_W-KEEP_W){1'b0}}, {KEEP_W{1'b1}}};
  localparam logic [EXC_N-1:0]  OU_MASK   = EXC_N'((1 << EX_OVER) | (1 << EX_UNDER));

  logic [STAT_W-1:0] kept;
  logic [EXC_N-1:0]  hit;

  always_comb begin
    kept   = stat_i & KEEP_MASK;
    hit    = exc_i & kept[ENA_LSB +: EXC_N];
    trap_o = |hit;

    nxt_stat_o = kept;
    nxt_excw_o = '0;
    if (trap_o) begin
      nxt_stat_o[TRAP_BIT] = 1'b1;
      if (|(hit & OU_MASK)) begin
        nxt_excw_o[COND_BIT]           = 1'b1;
        nxt_excw_o[FLAG_LSB + EX_OVER] = 1'b1;
      end else begin
        nxt_excw_o[FLAG_LSB +: EXC_N] = exc_i;
      end
    end
  end

endmodule

// File: rtl/fpst_round_dec.sv
module fpst_round_dec #(
  parameter int RND_W = 2
) (
  input  logic [RND_W-1:0]      field_i,
  output logic [(1<<RND_W)-1:0] sel_o
);
  localparam int N_MODES = 1 << RND_W;

  for (genvar m = 0; m < N_MODES; m++) begin : g_mode
    assign sel_o[m] = (field_i == RND_W'(m));
  end

endmodule

// File: rtl/fpst_stat_reg.sv
module fpst_stat_reg #(
  parameter int STAT_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ld_vld_i,
  input  logic [STAT_W-1:0] ld_word_i,
  input  logic              op_vld_i,
  input  logic [STAT_W-1:0] nxt_stat_i,
  input  logic [STAT_W-1:0] nxt_excw_i,
  input  logic              trap_i,
  output logic [STAT_W-1:0] stat_q,
  output logic [STAT_W-1:0] excw_q,
  output logic              trap_q
);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      stat_q <= '0;
      excw_q <= '0;
      trap_q <= 1'b0;
    end else begin
      trap_q <= 1'b0;
      if (ld_vld_i) begin
        stat_q <= ld_word_i;
      end else if (op_vld_i) begin
        stat_q <= nxt_stat_i;
        excw_q <= nxt_excw_i;
        trap_q <= trap_i;
      end
    end
  end

endmodule

// File: rtl/fpst_trap_unit.sv
module fpst_trap_unit
  import fpst_pkg::*;
#(
  parameter int STAT_W = 32,
  parameter int EXC_N  = 5,
  parameter int KEEP_W = 26,
  parameter int RND_W  = 2
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  ld_vld_i,
  input  logic [STAT_W-1:0]     ld_word_i,
  input  logic                  op_vld_i,
  input  logic [EXC_N-1:0]      op_exc_i,
  output logic [STAT_W-1:0]     status_o,
  output logic [STAT_W-1:0]     excw_o,
  output logic                  trap_o,
  output logic [(1<<RND_W)-1:0] rmode_o,
  output logic                  ftz_o
);
  logic [STAT_W-1:0] nxt_stat;
  logic [STAT_W-1:0] nxt_excw;
  logic              trap_hit;

  fpst_trap_eval #(
    .STAT_W(STAT_W), .EXC_N(EXC_N), .KEEP_W(KEEP_W)
  ) i_eval (
    .stat_i    (status_o),
    .exc_i     (op_exc_i),
    .nxt_stat_o(nxt_stat),
    .nxt_excw_o(nxt_excw),
    .trap_o    (trap_hit)
  );

  fpst_stat_reg #(.STAT_W(STAT_W)) i_reg (
    .clk       (clk),
    .rst_n     (rst_n),
    .ld_vld_i  (ld_vld_i),
    .ld_word_i (ld_word_i),
    .op_vld_i  (op_vld_i),
    .nxt_stat_i(nxt_stat),
    .nxt_excw_i(nxt_excw),
    .trap_i    (trap_hit),
    .stat_q    (status_o),
    .excw_q    (excw_o),
    .trap_q    (trap_o)
  );

  fpst_round_dec #(.RND_W(RND_W)) i_rnd (
    .field_i(status_o[RND_LSB +: RND_W]),
    .sel_o  (rmode_o)
  );

  assign ftz_o = status_o[FTZ_BIT];

endmodule

// File: rtl/fpst_trap_chk.sv
module fpst_trap_chk #(
  parameter int STAT_W = 32,
  parameter int EXC_N  = 5,
  parameter int RND_W  = 2
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  ld_vld_i,
  input logic [STAT_W-1:0]     ld_word_i,
  input logic                  op_vld_i,
  input logic [EXC_N-1:0]      op_exc_i,
  input logic [STAT_W-1:0]     status_o,
  input logic [STAT_W-1:0]     excw_o,
  input logic                  trap_o,
  input logic [(1<<RND_W)-1:0] rmode_o
);

  AST_LOAD_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    $past(ld_vld_i && rst_n) |-> status_o == $past(ld_word_i) && !trap_o); // R3

  AST_HIGH_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
    $past(op_vld_i && !ld_vld_i && rst_n) |-> status_o[STAT_W-1:26] == '0); // R6

  AST_QUIET_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    $past(op_vld_i && !ld_vld_i && rst_n && op_exc_i == '0) |-> excw_o == '0 && !trap_o); // R7

  AST_TRAP_FROM_OP: assert property (@(posedge clk) disable iff (!rst_n)
    trap_o |-> $past(op_vld_i && !ld_vld_i) && status_o[6]); // R8

  AST_OVF_FORM: assert property (@(posedge clk) disable iff (!rst_n)
    trap_o && excw_o[26] |-> excw_o == STAT_W'(32'h2400_0000)); // R10

  AST_RMODE_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(rmode_o) == 1); // R4

endmodule

bind fpst_trap_unit fpst_trap_chk #(
  .STAT_W(STAT_W), .EXC_N(EXC_N), .RND_W(RND_W)
) i_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .ld_vld_i (ld_vld_i),
  .ld_word_i(ld_word_i),
  .op_vld_i (op_vld_i),
  .op_exc_i (op_exc_i),
  .status_o (status_o),
  .excw_o   (excw_o),
  .trap_o   (trap_o),
  .rmode_o  (rmode_o)
);

// File: tb/test_fpst_trap_unit.sv
`timescale 1ns/1ps
module test_fpst_trap_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ld_vld_i = 1'b0;
  logic [31:0] ld_word_i = '0;
  logic        op_vld_i = 1'b0;
  logic [4:0]  op_exc_i = '0;
  logic [31:0] status_o, excw_o;
  logic        trap_o, ftz_o;
  logic [3:0]  rmode_o;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  logic [31:0] m_stat = '0;
  logic [31:0] m_excw = '0;
  logic        m_trap = 1'b0;

  always #2 clk = ~clk;

  fpst_trap_unit i_fpst_trap_unit (
    .clk(clk), .rst_n(rst_n), .ld_vld_i(ld_vld_i), .ld_word_i(ld_word_i),
    .op_vld_i(op_vld_i), .op_exc_i(op_exc_i), .status_o(status_o),
    .excw_o(excw_o), .trap_o(trap_o), .rmode_o(rmode_o), .ftz_o(ftz_o)
  );

  task automatic chk(string tag, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  function automatic logic [31:0] exp_excw(logic [31:0] st, logic [4:0] exc);
    logic [4:0] hit = exc & st[4:0];
    if (hit == 5'd0) return 32'h0;
    if ((hit & 5'b00110) != 5'd0) return 32'h2400_0000; // R10
    return {exc, 27'd0}; // R11
  endfunction

  function automatic logic [31:0] exp_stat(logic [31:0] st, logic [4:0] exc);
    logic [31:0] k = st & 32'h03FF_FFFF;
    if ((exc & k[4:0]) != 5'd0) k[6] = 1'b1;
    return k;
  endfunction

  task automatic check_all(string tag);
    chk(tag, "status", status_o, m_stat);
    chk(tag, "excw", excw_o, m_excw);
    chk(tag, "trap", {31'd0, trap_o}, {31'd0, m_trap});
    chk(tag, "rmode", {28'd0, rmode_o}, {28'd0, 4'b0001 << m_stat[10:9]});
    chk(tag, "ftz", {31'd0, ftz_o}, {31'd0, m_stat[5]});
  endtask

  task automatic step(logic ld, logic [31:0] w, logic op, logic [4:0] exc, string tag);
    ld_vld_i = ld; ld_word_i = w; op_vld_i = op; op_exc_i = exc;
    if (ld) begin
      m_stat = w; m_trap = 1'b0;
    end else if (op) begin
      m_trap = (exc & m_stat[4:0]) != 5'd0;
      m_excw = exp_excw(m_stat, exc);
      m_stat = exp_stat(m_stat, exc);
    end else begin
      m_trap = 1'b0;
    end
    @(negedge clk);
    ld_vld_i = 1'b0; op_vld_i = 1'b0;
    check_all(tag);
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 100000) begin
        errors++; checks++;
        $display("FAIL watchdog: actual %0d cycles expected under 100000", cycles);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
      end
    end
  end

  initial begin
    void'($urandom(32'h5EED_1234));
    repeat (3) @(negedge clk);
    check_all("R1");
    rst_n = 1'b1;
    @(negedge clk);
    check_all("R1");

    step(1, 32'hFFFF_FFFF, 0, 5'd0, "R2");
    step(1, 32'h0000_0200, 0, 5'd0, "R4");
    step(1, 32'h0000_0400, 0, 5'd0, "R4");
    step(1, 32'h0000_0600, 0, 5'd0, "R4");
    step(1, 32'h0000_0020, 0, 5'd0, "R5");
    step(1, 32'h0000_0000, 1, 5'h1F, "R3");
    step(1, 32'hFC00_001F, 1, 5'h1F, "R3");
    step(0, 32'h0, 1, 5'd0, "R7");
    step(0, 32'h0, 1, 5'd0, "R6");
    step(1, 32'hFFFF_FFE0, 0, 5'd0, "R2");
    step(0, 32'h0, 1, 5'h1F, "R9");
    step(1, 32'h0000_0004, 0, 5'd0, "R2");
    step(0, 32'h0, 1, 5'b00101, "R10");
    step(0, 32'h0, 0, 5'd0, "R8");
    step(1, 32'h0000_0002, 0, 5'd0, "R2");
    step(0, 32'h0, 1, 5'b00011, "R10");
    step(1, 32'h0000_0001, 0, 5'd0, "R2");
    step(0, 32'h0, 1, 5'b00101, "R11");
    step(1, 32'h0000_0010, 0, 5'd0, "R2");
    step(0, 32'h0, 1, 5'b10001, "R11");
    step(0, 32'h0, 1, 5'b10001, "R8");
    step(0, 32'h0, 1, 5'd0, "R7");

    for (int i = 0; i < 3000; i++) begin
      int r = $urandom_range(0, 99);
      logic [31:0] w = $urandom;
      logic [4:0] e = 5'($urandom);
      if ($urandom_range(0, 3) == 0) e = 5'd0;
      step(r < 20, w, r >= 10 && r < 80, e, "R8");
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule